// File: doc/BRIEF.md
# Clamped PWM Duty-Cycle Encoder

This block turns a signed digital field sample into a pulse-width-modulated line. The duty, held in tenths of a percent, is a quiescent level plus a scaled field term, and it is then limited to a fixed window. The quiescent level depends on the polarity mode. In bipolar mode the quiescent level is 50.0% and the field moves the duty either way. In unipolar mode the quiescent level is 20.0% and only positive fields raise it. A signed trim code shifts the quiescent level in either mode.

The carrier period is counted in system clock ticks. A range bit picks a short or a long base period, and a 4-bit fine code shortens the period in equal steps. A new period length and a new high time are latched together at every period boundary, and a one-cycle strobe marks each boundary. When calibration is enabled, the first periods after reset carry only the quiescent duty, so a tester can measure the zero-field level. Because the window is counted in carrier periods, its length in time follows the programmed carrier.

Top module: `pwm_duty_enc`

## Requirements
- R1: While reset is high, `pwm_o` and `per_start_o` are 0. The first period starts on the first clock edge after reset is released, and its strobe is visible in the cycle after that edge.
- R2: `per_start_o` is high for exactly the first cycle of every period. A period lasts FAST_BASE − fine·FAST_STEP ticks when `fast_i`=1 (defaults 100 and 2) and SLOW_BASE − fine·SLOW_STEP ticks when `fast_i`=0 (defaults 400 and 8).
- R3: In a period of P ticks with duty D (in tenths of a percent), `pwm_o` is high for the first floor(P·D/1000) cycles and low for the rest.
- R4: In bipolar mode (`unipolar_i`=0) the unclamped duty is 500 + trim + T. T is floor(sample·sens/64), with sample a signed 12-bit value and sens an unsigned 8-bit value, and T is saturated to ±1000.
- R5: In unipolar mode (`unipolar_i`=1) the quiescent level is 200 + trim, and a negative sample contributes T = 0.
- R6: The duty is clamped to the range 75..925. This also applies to a quiescent level pushed below 75 by the trim.
- R7: Inputs are sampled only at a period boundary. A change in the middle of a period leaves that period's length and high time unchanged and takes effect from the next period.
- R8: With `cal_en_i`=1, the first 100 periods after reset use the clamped quiescent duty whatever the sample. From period 101 on, the duty follows the sample.
- R9: With `cal_en_i`=0, the duty follows the sample from the first period after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all timing is counted in its ticks |
| rst_i | input | 1 | Synchronous active-high reset |
| sample_i | input | 12 | Signed field sample |
| sens_i | input | 8 | Unsigned sensitivity multiplier |
| qtrim_i | input | 8 | Signed trim of the quiescent duty, in tenths of a percent |
| fine_i | input | 4 | Fine carrier-period code; a higher value gives a shorter period |
| fast_i | input | 1 | Carrier range: 1 selects the short base period, 0 the long one |
| unipolar_i | input | 1 | 1 selects unipolar quiescent level and ignores negative fields |
| cal_en_i | input | 1 | Enables the quiescent-only window after reset |
| pwm_o | output | 1 | PWM line |
| per_start_o | output | 1 | One-cycle strobe in the first cycle of each period |

## Verification
Directed cases cover several situations. Zero, positive and negative samples in bipolar mode show that the field term adds in both directions, and a tiny negative product shows that the scaling rounds toward minus infinity. Full-scale samples of both signs, together with the lowest trim in unipolar mode, reach each clamp. A negative sample in unipolar mode must leave the quiescent level untouched. The extreme fine codes in each range check the period arithmetic. Random samples, codes and modes then exercise the whole sum-clamp-scale path against a model in the bench. A change in mid-period tells latching at the boundary apart from direct tracking of the inputs. Two reset runs, with calibration on and off, tell the 100-period quiescent window apart from its absence, and show where that window ends.

// File: rtl/pwm_duty_enc.sv
module pwm_duty_enc #(
  parameter int SMP_W       = 12,
  parameter int SENS_W      = 8,
  parameter int QT_W        = 8,
  parameter int FINE_W      = 4,
  parameter int SHIFT       = 6,
  parameter int FAST_BASE   = 100,
  parameter int FAST_STEP   = 2,
  parameter int SLOW_BASE   = 400,
  parameter int SLOW_STEP   = 8,
  parameter int CAL_PERIODS = 100,
  parameter int Q_BI        = 500,
  parameter int Q_UNI       = 200,
  parameter int CLAMP_LO    = 75,
  parameter int CLAMP_HI    = 925,
  parameter int SPAN        = 1000
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic signed [SMP_W-1:0]  sample_i,
  input  logic [SENS_W-1:0]        sens_i,
  input  logic signed [QT_W-1:0]   qtrim_i,
  input  logic [FINE_W-1:0]        fine_i,
  input  logic                     fast_i,
  input  logic                     unipolar_i,
  input  logic                     cal_en_i,
  output logic                     pwm_o,
  output logic                     per_start_o
);
  localparam int MAXP = (FAST_BASE > SLOW_BASE) ? FAST_BASE : SLOW_BASE;
  localparam int PW   = $clog2(MAXP + 1);
  localparam int UW   = $clog2(SPAN + 1);
  localparam int DW   = $clog2(2 * SPAN + 1) + 1;
  localparam int PRW  = SMP_W + SENS_W + 1;
  localparam int CW   = $clog2(CAL_PERIODS + 1);
  localparam int MW   = PW + UW;

  logic signed [PRW-1:0] prod, scaled;
  logic signed [DW-1:0]  term, qlvl, fsum;
  logic [UW-1:0]         duty_nxt;
  logic [PW-1:0]         per_nxt, hi_nxt;
  logic [MW-1:0]         mul;

  logic                  run;
  logic [PW-1:0]         cnt, per_q, hi_q;
  logic [CW-1:0]         cal_cnt;
  logic                  hold, load;

  function automatic logic [UW-1:0] clamp(input logic signed [DW-1:0] v);
    if (v < DW'(CLAMP_LO))      return UW'(CLAMP_LO);
    else if (v > DW'(CLAMP_HI)) return UW'(CLAMP_HI);
    else                        return UW'(v);
  endfunction

  assign prod   = PRW'(sample_i) * PRW'($signed({1'b0, sens_i}));
  assign scaled = prod >>> SHIFT;

  always_comb begin
    if (unipolar_i && sample_i[SMP_W-1]) term = '0;
    else if (scaled > PRW'(SPAN))        term = DW'(SPAN);
    else if (scaled < -PRW'(SPAN))       term = -DW'(SPAN);
    else                                 term = DW'(scaled);
  end

  assign qlvl     = DW'(unipolar_i ? Q_UNI : Q_BI) + DW'(qtrim_i);
  assign fsum     = qlvl + term;
  assign hold     = cal_en_i && (cal_cnt < CW'(CAL_PERIODS));
  assign duty_nxt = hold ? clamp(qlvl) : clamp(fsum);

  assign per_nxt = fast_i ? PW'(FAST_BASE) - PW'(FAST_STEP) * PW'(fine_i)
                          : PW'(SLOW_BASE) - PW'(SLOW_STEP) * PW'(fine_i);
  assign mul     = MW'(per_nxt) * MW'(duty_nxt);
  assign hi_nxt  = PW'(mul / MW'(SPAN));

  assign load = !run || (cnt == per_q - PW'(1));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      run     <= 1'b0;
      cnt     <= '0;
      per_q   <= '0;
      hi_q    <= '0;
      cal_cnt <= '0;
    end else if (load) begin
      run   <= 1'b1;
      cnt   <= '0;
      per_q <= per_nxt;
      hi_q  <= hi_nxt;
      if (cal_cnt != CW'(CAL_PERIODS)) cal_cnt <= cal_cnt + CW'(1);
    end else begin
      cnt <= cnt + PW'(1);
    end
  end

  assign pwm_o       = run && (cnt < hi_q);
  assign per_start_o = run && (cnt == '0);
endmodule

// File: rtl/pwm_duty_enc_chk.sv
module pwm_duty_enc_chk #(
  parameter int MIN_PER = 70,
  parameter int MAX_PER = 400
) (
  input logic clk_i,
  input logic rst_i,
  input logic pwm_o,
  input logic per_start_o
);
  logic [15:0] gap;
  logic        seen, low_seen;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      gap      <= '0;
      seen     <= 1'b0;
      low_seen <= 1'b0;
    end else if (per_start_o) begin
      gap      <= 16'd1;
      seen     <= 1'b1;
      low_seen <= 1'b0;
    end else begin
      if (gap != 16'hFFFF) gap <= gap + 16'd1;
      if (!pwm_o) low_seen <= 1'b1;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    $past(rst_i) |-> (!pwm_o && !per_start_o));

  p_period_span_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (seen && per_start_o) |-> (gap >= 16'(MIN_PER) && gap <= 16'(MAX_PER)));

  p_start_high_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    per_start_o |-> pwm_o);

  p_rise_at_start_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(pwm_o) |-> per_start_o);

  p_low_each_period_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (seen && per_start_o) |-> low_seen);
endmodule

bind pwm_duty_enc pwm_duty_enc_chk #(
  .MIN_PER((FAST_BASE - ((1 << FINE_W) - 1) * FAST_STEP) <
           (SLOW_BASE - ((1 << FINE_W) - 1) * SLOW_STEP) ?
           (FAST_BASE - ((1 << FINE_W) - 1) * FAST_STEP) :
           (SLOW_BASE - ((1 << FINE_W) - 1) * SLOW_STEP)),
  .MAX_PER((FAST_BASE > SLOW_BASE) ? FAST_BASE : SLOW_BASE)
) i_pwm_duty_enc_chk (
  .clk_i(clk_i),
  .rst_i(rst_i),
  .pwm_o(pwm_o),
  .per_start_o(per_start_o)
);

// File: tb/test_pwm_duty_enc.sv
`timescale 1ns/1ps
module test_pwm_duty_enc;
  logic              clk = 1'b0;
  logic              rst;
  logic signed [11:0] sample;
  logic [7:0]        sens;
  logic signed [7:0] qtrim;
  logic [3:0]        fine;
  logic              fast, uni, cal_en;
  logic              pwm, per_start;

  int n_tests = 0;
  int n_fail  = 0;
  int pers[0:127];
  int his[0:127];
  int wcnt;
  int b_s, b_se, b_q, b_f;
  bit b_fa, b_u;

  always #2.5 clk = ~clk;

  pwm_duty_enc i_pwm_duty_enc (
    .clk_i(clk), .rst_i(rst), .sample_i(sample), .sens_i(sens),
    .qtrim_i(qtrim), .fine_i(fine), .fast_i(fast), .unipolar_i(uni),
    .cal_en_i(cal_en), .pwm_o(pwm), .per_start_o(per_start)
  );

  function automatic int e_per(bit fa, int f);
    return fa ? 100 - f * 2 : 400 - f * 8;
  endfunction

  function automatic int e_clamp(int v);
    if (v < 75) return 75;
    if (v > 925) return 925;
    return v;
  endfunction

  function automatic int e_duty(int s, int se, int q, bit u);
    int t;
    t = (s * se) >>> 6;
    if (u && s < 0) t = 0;
    if (t > 1000) t = 1000;
    if (t < -1000) t = -1000;
    return e_clamp((u ? 200 : 500) + q + t);
  endfunction

  function automatic int e_hi(int p, int d);
    return (p * d) / 1000;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(int s, int se, int q, int f, bit fa, bit u);
    sample = 12'(s); sens = 8'(se); qtrim = 8'(q);
    fine = 4'(f); fast = fa; uni = u;
  endtask

  task automatic measure_n(int n, int mid_at);
    wcnt = 0;
    do begin @(negedge clk); wcnt++; end while (!per_start);
    for (int k = 0; k < n; k++) begin
      int p, h;
      p = 1; h = int'(pwm);
      forever begin
        @(negedge clk);
        if (per_start) break;
        p++; h += int'(pwm);
        if (k == 0 && p == mid_at) apply(b_s, b_se, b_q, b_f, b_fa, b_u);
      end
      pers[k] = p; his[k] = h;
    end
  endtask

  task automatic run_case(string req, int s, int se, int q, int f, bit fa, bit u);
    int p;
    apply(s, se, q, f, fa, u);
    measure_n(1, 0);
    p = e_per(fa, f);
    chk(req, pers[0], p);
    chk(req, his[0], e_hi(p, e_duty(s, se, q, u)));
  endtask

  initial begin
    #(5.0 * 190000);
    n_tests++; n_fail++;
    $display("FAIL R2: watchdog expired, actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int bad;
    void'($urandom(32'd4242));
    rst = 1'b1; cal_en = 1'b0;
    apply(400, 64, 0, 0, 1'b1, 1'b0);
    repeat (4) begin
      @(negedge clk);
      chk("R1 pwm in reset", int'(pwm), 0);
      chk("R1 strobe in reset", int'(per_start), 0);
    end
    rst = 1'b0;
    measure_n(1, 0);
    chk("R1 first strobe delay", wcnt, 1);
    chk("R9 first period follows field", his[0], 90);

    run_case("R4 zero field bipolar", 0, 100, 0, 0, 1'b1, 1'b0);
    run_case("R4 positive field", 320, 64, 0, 5, 1'b1, 1'b0);
    run_case("R4 negative field", -200, 64, 0, 3, 1'b0, 1'b0);
    run_case("R4 floor toward minus", -3, 1, 0, 0, 1'b1, 1'b0);
    run_case("R4 trim shifts level", 0, 0, 37, 0, 1'b1, 1'b0);
    run_case("R6 high clamp", 2047, 255, 0, 0, 1'b0, 1'b0);
    run_case("R6 low clamp", -2048, 255, 0, 0, 1'b1, 1'b0);
    run_case("R5 unipolar zero", 0, 100, 0, 0, 1'b1, 1'b1);
    run_case("R5 unipolar negative ignored", -500, 200, 10, 0, 1'b1, 1'b1);
    run_case("R5 unipolar positive", 300, 128, 0, 2, 1'b1, 1'b1);
    run_case("R6 trim below clamp", 0, 0, -128, 0, 1'b1, 1'b1);
    run_case("R2 fast max fine", 100, 64, 0, 15, 1'b1, 1'b0);
    run_case("R2 slow max fine", 100, 64, 0, 15, 1'b0, 1'b0);

    for (int i = 0; i < 40; i++) begin
      run_case("R3 random", int'($urandom_range(4095)) - 2048,
               int'($urandom_range(255)), int'($urandom_range(255)) - 128,
               int'($urandom_range(15)), 1'($urandom_range(1)),
               1'($urandom_range(1)));
    end

    apply(0, 0, 0, 0, 1'b1, 1'b0);
    b_s = 1000; b_se = 64; b_q = 0; b_f = 10; b_fa = 1'b1; b_u = 1'b0;
    measure_n(1, 10);
    chk("R7 mid change period kept", pers[0], 100);
    chk("R7 mid change high kept", his[0], 50);
    measure_n(1, 0);
    chk("R7 next period length", pers[0], 80);
    chk("R7 next period high", his[0], 74);

    @(negedge clk);
    rst = 1'b1; cal_en = 1'b1;
    apply(400, 64, 0, 0, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    measure_n(102, 0);
    bad = 0;
    for (int k = 0; k < 100; k++) if (his[k] != 50) bad++;
    chk("R8 quiescent periods in window", bad, 0);
    chk("R8 period 100 quiescent", his[99], 50);
    chk("R8 period 101 follows field", his[100], 90);
    chk("R8 period 102 follows field", his[101], 90);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule